// File: doc/BRIEF.md
# I2C Byte Data Buffer

This block is the single-byte holding stage between a processor's 16-bit data register and an I2C bit shifter. One 8-bit register serves both directions. In transmit mode, a processor write loads the register and offers the byte to the shifter. When the shifter takes the byte, the transmit-empty flag rises. A byte written while that flag is high keeps the bus streaming with no gap.

In receive mode, each completed byte from the shifter is loaded into the same register and the receive-not-empty flag is raised. A processor read clears that flag. Address bytes are never loaded. A byte that completes together with an arbitration loss is discarded. A byte that arrives while the previous one is still unread is dropped, and an overrun pulse reports it.

The bit shifter, the pin drivers and address matching are outside the block. They reach it only through single-cycle strobes.

Top module: `i2c_dbuf`

## Requirements
- R1: After reset, `cpu_rdata_o` is 0x0000 and `txe_o`, `rxne_o`, `overrun_o` and `eng_tx_valid_o` are all 0.
- R2: `cpu_rdata_o` is the held byte in bits 7:0 with bits 15:8 always 0. Bits 15:8 of a write are discarded.
- R3: A write while enabled stores `cpu_wdata_i[7:0]`. On the next cycle `txe_o` is 0. In transmit mode (`tx_mode_i`=1), `eng_tx_valid_o` is 1 with that byte on `eng_tx_byte_o`.
- R4: When `eng_tx_take_i` is high while `eng_tx_valid_o` is high, the next cycle has `txe_o`=1 and `eng_tx_valid_o`=0. A write in the same cycle as the take instead leaves the new byte offered, with `txe_o`=0 (back-to-back transmit).
- R5: A write while `txe_o`=0 overwrites the pending byte. No collision indication is given, and the shifter receives the latest byte.
- R6: A byte completion (`eng_rx_done_i`) in receive mode (`tx_mode_i`=0) loads `eng_rx_byte_i` and sets `rxne_o` on the next cycle. Completions in transmit mode are ignored.
- R7: A read clears `rxne_o` on the next cycle. A read in the same cycle as a completion accepts the new byte: `rxne_o` stays 1 and there is no overrun.
- R8: A completion flagged as an address (`eng_rx_addr_i`=1) loads nothing and leaves `rxne_o` unchanged.
- R9: A completion together with `eng_arb_lost_i`=1 is discarded. The register and `rxne_o` are unchanged.
- R10: A completion while `rxne_o`=1 and no read is in progress keeps the old byte and raises `overrun_o` for exactly one cycle.
- R11: While `enable_i`=0, the flags and the pending transmit byte are cleared on the next cycle. Completions and takes are ignored, so the byte is not re-offered after re-enable.
- R12: When a completion is accepted in the same cycle as a processor write, the received byte wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Peripheral enable |
| tx_mode_i | input | 1 | 1 = transmitter, 0 = receiver |
| cpu_wr_i | input | 1 | Processor write strobe |
| cpu_rd_i | input | 1 | Processor read strobe |
| cpu_wdata_i | input | 16 | Processor write data |
| cpu_rdata_o | output | 16 | Register read value |
| txe_o | output | 1 | Transmit-empty flag |
| rxne_o | output | 1 | Receive-not-empty flag |
| overrun_o | output | 1 | One-cycle pulse when a received byte is lost |
| eng_tx_valid_o | output | 1 | A byte is offered to the shifter |
| eng_tx_byte_o | output | 8 | Byte offered to the shifter |
| eng_tx_take_i | input | 1 | Shifter loads the offered byte |
| eng_rx_done_i | input | 1 | Shifter has completed a received byte |
| eng_rx_byte_i | input | 8 | Completed received byte |
| eng_rx_addr_i | input | 1 | The completed byte was an address |
| eng_arb_lost_i | input | 1 | Arbitration lost on the acknowledge of this byte |

## Verification
Several relations are checked on every cycle:
- a write clears transmit-empty;
- an uncontested take sets transmit-empty;
- disabling clears the flags;
- a discarded completion leaves receive-not-empty unchanged;
- an overrun only follows a full buffer;
- a full buffer keeps its byte;
- an accepted byte lands in the register.

Only the directed scenarios can show the rest: the exact byte values on the read port and to the shifter, the back-to-back and overwrite orderings, that the overrun pulse lasts exactly one cycle, and the priority of a received byte over a same-cycle write.

// File: rtl/i2c_dbuf_pkg.sv
package i2c_dbuf_pkg;

    // Transmit-side state: a byte is waiting for the shifter, and the
    // shifter has taken the last one.
    typedef struct packed {
        logic pend;
        logic txe;
    } tx_state_t;

    // Receive-side state: unread byte present, and a one-cycle loss pulse.
    typedef struct packed {
        logic rxne;
        logic ovr;
    } rx_state_t;

endpackage

// File: rtl/i2c_dbuf_tx.sv
module i2c_dbuf_tx
    import i2c_dbuf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic tx_mode_i,
    input  logic cpu_wr_i,
    input  logic take_i,
    output logic pend_o,
    output logic txe_o,
    output logic offer_o
);

    tx_state_t tx_d, tx_q;
    logic      take_ok;

    always_comb begin
        tx_d    = tx_q;
        offer_o = tx_q.pend & en_i & tx_mode_i;
        take_ok = offer_o & take_i;
        if (!en_i) begin
            tx_d = '0;
        end else begin
            if (take_ok) begin
                tx_d.pend = 1'b0;
                tx_d.txe  = 1'b1;
            end
            // A write outranks a same-cycle take: the new byte stays queued.
            if (cpu_wr_i) begin
                tx_d.pend = 1'b1;
                tx_d.txe  = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tx_q <= '0;
        else        tx_q <= tx_d;
    end

    assign pend_o = tx_q.pend;
    assign txe_o  = tx_q.txe;

    // R3
    wr_clears_txe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && cpu_wr_i) |=> (!txe_o && pend_o));

    // R4
    take_sets_txe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && offer_o && take_i && !cpu_wr_i) |=> (txe_o && !pend_o));

    // R11
    dis_clears_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (!txe_o && !pend_o));

endmodule

// File: rtl/i2c_dbuf_rx.sv
module i2c_dbuf_rx
    import i2c_dbuf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic tx_mode_i,
    input  logic cpu_rd_i,
    input  logic done_i,
    input  logic is_addr_i,
    input  logic arb_lost_i,
    output logic load_o,
    output logic rxne_o,
    output logic ovr_o
);

    rx_state_t rx_d, rx_q;
    logic      accept;
    logic      room;

    always_comb begin
        rx_d   = rx_q;
        // Address bytes and bytes lost to arbitration never qualify.
        accept = en_i & ~tx_mode_i & done_i & ~is_addr_i & ~arb_lost_i;
        // A read in the same cycle frees the slot for the incoming byte.
        room   = ~rx_q.rxne | cpu_rd_i;
        load_o = accept & room;
        rx_d.ovr = accept & ~room;
        if (!en_i)         rx_d.rxne = 1'b0;
        else if (load_o)   rx_d.rxne = 1'b1;
        else if (cpu_rd_i) rx_d.rxne = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rx_q <= '0;
        else        rx_q <= rx_d;
    end

    assign rxne_o = rx_q.rxne;
    assign ovr_o  = rx_q.ovr;

    // R10
    ovr_after_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_o |-> $past(rxne_o));

    // R8 R9
    drop_keeps_rxne_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && done_i && (is_addr_i || arb_lost_i) && !cpu_rd_i) |=> $stable(rxne_o));

    // R7
    rd_clears_rxne_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && cpu_rd_i && !done_i) |=> !rxne_o);

    // R11
    dis_clears_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (!rxne_o && !ovr_o));

endmodule

// File: rtl/i2c_dbuf.sv
module i2c_dbuf #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned REG_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable_i,
    input  logic              tx_mode_i,
    input  logic              cpu_wr_i,
    input  logic              cpu_rd_i,
    input  logic [REG_W-1:0]  cpu_wdata_i,
    output logic [REG_W-1:0]  cpu_rdata_o,
    output logic              txe_o,
    output logic              rxne_o,
    output logic              overrun_o,
    output logic              eng_tx_valid_o,
    output logic [DATA_W-1:0] eng_tx_byte_o,
    input  logic              eng_tx_take_i,
    input  logic              eng_rx_done_i,
    input  logic [DATA_W-1:0] eng_rx_byte_i,
    input  logic              eng_rx_addr_i,
    input  logic              eng_arb_lost_i
);

    localparam int unsigned PAD_W = REG_W - DATA_W;

    logic [DATA_W-1:0] data_d, data_q;
    logic              rx_load;
    logic              tx_pend;

    i2c_dbuf_tx u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (enable_i),
        .tx_mode_i (tx_mode_i),
        .cpu_wr_i  (cpu_wr_i),
        .take_i    (eng_tx_take_i),
        .pend_o    (tx_pend),
        .txe_o     (txe_o),
        .offer_o   (eng_tx_valid_o)
    );

    i2c_dbuf_rx u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (enable_i),
        .tx_mode_i  (tx_mode_i),
        .cpu_rd_i   (cpu_rd_i),
        .done_i     (eng_rx_done_i),
        .is_addr_i  (eng_rx_addr_i),
        .arb_lost_i (eng_arb_lost_i),
        .load_o     (rx_load),
        .rxne_o     (rxne_o),
        .ovr_o      (overrun_o)
    );

    always_comb begin
        data_d = data_q;
        // A received byte takes priority over a same-cycle processor write.
        if (rx_load)       data_d = eng_rx_byte_i;
        else if (cpu_wr_i) data_d = cpu_wdata_i[DATA_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) data_q <= '0;
        else        data_q <= data_d;
    end

    assign cpu_rdata_o   = {{PAD_W{1'b0}}, data_q};
    assign eng_tx_byte_o = data_q;

    // R12
    rx_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_load |=> (data_q == $past(eng_rx_byte_i)));

    // R10
    full_keeps_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rxne_o && eng_rx_done_i && !cpu_rd_i && !cpu_wr_i) |=> $stable(data_q));

    // R3
    offer_needs_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_tx_valid_o |-> (tx_pend && !txe_o));

endmodule

// File: tb/tb_i2c_dbuf.sv
`timescale 1ns/1ps
module tb_i2c_dbuf;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable_i = 1'b0, tx_mode_i = 1'b0;
    logic        cpu_wr_i = 1'b0, cpu_rd_i = 1'b0;
    logic [15:0] cpu_wdata_i = '0;
    logic [15:0] cpu_rdata_o;
    logic        txe_o, rxne_o, overrun_o, eng_tx_valid_o;
    logic [7:0]  eng_tx_byte_o;
    logic        eng_tx_take_i = 1'b0, eng_rx_done_i = 1'b0;
    logic [7:0]  eng_rx_byte_i = '0;
    logic        eng_rx_addr_i = 1'b0, eng_arb_lost_i = 1'b0;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    i2c_dbuf dut (.*);

    task automatic chk(input bit ok, input string tag, input logic [15:0] act,
                       input logic [15:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic do_wr(input logic [15:0] v);
        cpu_wr_i = 1'b1; cpu_wdata_i = v;
        tick();
        cpu_wr_i = 1'b0;
    endtask

    task automatic do_rd();
        cpu_rd_i = 1'b1;
        tick();
        cpu_rd_i = 1'b0;
    endtask

    task automatic do_take();
        eng_tx_take_i = 1'b1;
        tick();
        eng_tx_take_i = 1'b0;
    endtask

    task automatic do_rx(input logic [7:0] b, input bit addr, input bit arb, input bit rd);
        eng_rx_done_i = 1'b1; eng_rx_byte_i = b;
        eng_rx_addr_i = addr; eng_arb_lost_i = arb; cpu_rd_i = rd;
        tick();
        eng_rx_done_i = 1'b0; eng_rx_addr_i = 1'b0; eng_arb_lost_i = 1'b0; cpu_rd_i = 1'b0;
    endtask

    task automatic t_reset();
        chk(cpu_rdata_o == 16'h0000, "R1 rdata", cpu_rdata_o, 16'h0000);
        chk({txe_o, rxne_o, overrun_o, eng_tx_valid_o} == 4'b0, "R1 flags",
            {12'h0, txe_o, rxne_o, overrun_o, eng_tx_valid_o}, 16'h0);
    endtask

    task automatic t_tx_basic();
        tx_mode_i = 1'b1;
        do_wr(16'hAB5C);
        chk(cpu_rdata_o == 16'h005C, "R2 upper bits dropped", cpu_rdata_o, 16'h005C);
        chk(eng_tx_valid_o && eng_tx_byte_o == 8'h5C, "R3 offer",
            {7'h0, eng_tx_valid_o, eng_tx_byte_o}, 16'h015C);
        chk(!txe_o, "R3 txe low", {15'h0, txe_o}, 16'h0);
        do_take();
        chk(txe_o && !eng_tx_valid_o, "R4 take", {14'h0, txe_o, eng_tx_valid_o}, 16'h2);
    endtask

    task automatic t_tx_b2b();
        do_wr(16'h0011);
        eng_tx_take_i = 1'b1; cpu_wr_i = 1'b1; cpu_wdata_i = 16'h0022;
        tick();
        eng_tx_take_i = 1'b0; cpu_wr_i = 1'b0;
        chk(!txe_o && eng_tx_valid_o && eng_tx_byte_o == 8'h22, "R4 back-to-back",
            {6'h0, txe_o, eng_tx_valid_o, eng_tx_byte_o}, 16'h0122);
        do_take();
        chk(txe_o, "R4 second take", {15'h0, txe_o}, 16'h1);
    endtask

    task automatic t_overwrite();
        do_wr(16'h0033);
        do_wr(16'h0044);
        chk(eng_tx_valid_o && eng_tx_byte_o == 8'h44 && !txe_o, "R5 overwrite",
            {6'h0, txe_o, eng_tx_valid_o, eng_tx_byte_o}, 16'h0144);
        chk(!overrun_o && !rxne_o, "R5 no indication", {14'h0, overrun_o, rxne_o}, 16'h0);
        do_take();
        chk(txe_o, "R5 take latest", {15'h0, txe_o}, 16'h1);
    endtask

    task automatic t_rx();
        do_rx(8'h55, 0, 0, 0);
        chk(!rxne_o && cpu_rdata_o == 16'h0044, "R6 ignored in tx mode",
            {rxne_o, cpu_rdata_o[14:0]}, 16'h0044);
        tx_mode_i = 1'b0;
        do_rx(8'h9A, 0, 0, 0);
        chk(rxne_o && cpu_rdata_o == 16'h009A, "R6 load",
            {rxne_o, cpu_rdata_o[14:0]}, 16'h809A);
        do_rd();
        chk(!rxne_o, "R7 read clears", {15'h0, rxne_o}, 16'h0);
    endtask

    task automatic t_rx_stream();
        do_rx(8'h01, 0, 0, 0);
        do_rx(8'h02, 0, 0, 1);
        chk(rxne_o && !overrun_o && cpu_rdata_o == 16'h0002, "R7 read with completion",
            {rxne_o, overrun_o, cpu_rdata_o[13:0]}, 16'h8002);
        do_rd();
    endtask

    task automatic t_addr_arb();
        do_rx(8'h77, 1, 0, 0);
        chk(!rxne_o && cpu_rdata_o == 16'h0002, "R8 address dropped",
            {rxne_o, cpu_rdata_o[14:0]}, 16'h0002);
        do_rx(8'h66, 0, 1, 0);
        chk(!rxne_o && cpu_rdata_o == 16'h0002, "R9 arbitration drop",
            {rxne_o, cpu_rdata_o[14:0]}, 16'h0002);
    endtask

    task automatic t_overrun();
        do_rx(8'h10, 0, 0, 0);
        do_rx(8'h20, 0, 0, 0);
        chk(overrun_o && rxne_o && cpu_rdata_o == 16'h0010, "R10 overrun keeps old",
            {overrun_o, rxne_o, cpu_rdata_o[13:0]}, 16'hC010);
        tick();
        chk(!overrun_o, "R10 pulse one cycle", {15'h0, overrun_o}, 16'h0);
        do_rd();
    endtask

    task automatic t_collide();
        eng_rx_done_i = 1'b1; eng_rx_byte_i = 8'hC3;
        cpu_wr_i = 1'b1; cpu_wdata_i = 16'h003C;
        tick();
        eng_rx_done_i = 1'b0; cpu_wr_i = 1'b0;
        chk(rxne_o && cpu_rdata_o == 16'h00C3, "R12 received wins",
            {rxne_o, cpu_rdata_o[14:0]}, 16'h80C3);
        do_rd();
    endtask

    task automatic t_disable();
        do_rx(8'h44, 0, 0, 0);
        do_wr(16'h005A);
        enable_i = 1'b0;
        tick();
        chk(!rxne_o && !txe_o, "R11 flags cleared", {14'h0, rxne_o, txe_o}, 16'h0);
        tx_mode_i = 1'b1;
        tick();
        chk(!eng_tx_valid_o, "R11 no offer while off", {15'h0, eng_tx_valid_o}, 16'h0);
        tx_mode_i = 1'b0;
        do_rx(8'h99, 0, 0, 0);
        chk(!rxne_o && cpu_rdata_o == 16'h005A, "R11 completion ignored",
            {rxne_o, cpu_rdata_o[14:0]}, 16'h005A);
        enable_i = 1'b1; tx_mode_i = 1'b1;
        tick();
        chk(!eng_tx_valid_o && !txe_o, "R11 pending dropped",
            {14'h0, eng_tx_valid_o, txe_o}, 16'h0);
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        enable_i = 1'b1;
        tick();
        t_tx_basic();
        t_tx_b2b();
        t_overwrite();
        t_rx();
        t_rx_stream();
        t_addr_arb();
        t_overrun();
        t_collide();
        t_disable();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        #100000;
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule